// File: doc/BRIEF.md
# Dual-Host Command Decoder

This block is the control hub of a small graphics subsystem. A serial-side host and an on-chip processor each reach it through a plain write and read strobe port with address and data. Both hosts write into one shared set of configuration registers: the horizontal and vertical display timing words, and the fields of the drawing object (kind, width, height, first pixel, mask offset, fill value).

A write to the launch address checks the loaded object. If it is valid, the block sends the drawing engine a one-cycle start pulse and then holds the object fields stable for as long as the engine reports busy. The block also owns the processor's memory-path enable and a soft reset for that path. A clear of the enable and a soft reset request are both latched and carried out only once memory traffic, and for the reset also drawing, have gone quiet.

Serial reads pass straight through from the host read FIFO. A watchdog flags a drawing engine that stays busy too long.

Top module: `dual_host_cmd_decoder`

## Requirements
- R1: After reset every output is zero. A write from either host loads the register at its address, keeping the low bits that fit the field. The addresses are: 0 horizontal timing, 1 vertical timing, 2 object kind, 3 width, 4 height, 5 first pixel, 6 mask offset, 7 fill value. The new value is visible after the clock edge that takes the write.
- R2: A processor write is accepted in a cycle where procWe is high, no serial write is present and procWrAck is low. procWrAck is high for exactly the one cycle after acceptance.
- R3: When both hosts write in the same cycle, the serial write is applied and the processor write waits. Its register update and acknowledge both come one cycle later than they would without the collision.
- R4: A write to address 8 gives a one-cycle drawStart in the next cycle, but only when the kind is below NUM_TYPES and both width and height exceed MIN_WH. Otherwise no pulse is issued.
- R5: While drawStart or drawBusy is high, writes to addresses 2 to 8 have no effect. Timing writes (addresses 0 and 1) still apply.
- R6: A serial write to address 18 sets procMemEn after that edge and cancels any pending enable clear.
- R7: A processor write to address 18 leaves procMemEn unchanged, and a processor write to address 9 does not push the FIFO.
- R8: A write to address 16 from either host latches a soft reset request. procSoftReset then pulses for one cycle, in the cycle after the first edge at which memPending, drawBusy and drawStart are all low.
- R9: A write to address 19 latches an enable-clear request. procMemEn falls only at an edge where memPending is low.
- R10: A processor read (procRe) is answered in the next cycle by a one-cycle procRdy. procRdata bit 0 carries drawBusy and bit 1 carries the timeout flag.
- R11: serRdata equals fifoRdata and fifoPop equals serRe in the same cycle. A serial write to address 9 drives fifoPush high with fifoWdata equal to the write data in that cycle.
- R12: If drawBusy stays high for more than TIMEOUT consecutive cycles, drawTimeout sets and stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| serWe | input | 1 | Serial-side write strobe |
| serAddr | input | ADDR_W | Serial-side write address |
| serWdata | input | DATA_W | Serial-side write data |
| serRe | input | 1 | Serial-side read strobe |
| serRdata | output | DATA_W | Serial-side read data |
| procWe | input | 1 | Processor write request, held until acknowledged |
| procAddr | input | ADDR_W | Processor write address |
| procWdata | input | DATA_W | Processor write data |
| procWrAck | output | 1 | Processor write acknowledge |
| procRe | input | 1 | Processor read request |
| procRdata | output | DATA_W | Processor read data (status) |
| procRdy | output | 1 | Processor read ready |
| fifoPush | output | 1 | Host write FIFO push |
| fifoWdata | output | DATA_W | Host write FIFO data |
| fifoPop | output | 1 | Host read FIFO pop |
| fifoRdata | input | DATA_W | Host read FIFO data |
| hTiming | output | DATA_W | Horizontal timing register |
| vTiming | output | DATA_W | Vertical timing register |
| objType | output | TYPE_W | Object kind |
| objWidth | output | DIM_W | Object width |
| objHeight | output | DIM_W | Object height |
| objStartPix | output | PIX_W | Object first pixel |
| objStartMask | output | MASK_W | Object mask offset |
| objFill | output | VALUE_W | Object fill value |
| drawStart | output | 1 | Drawing start pulse |
| drawBusy | input | 1 | Drawing engine busy |
| drawTimeout | output | 1 | Sticky busy-timeout flag |
| memPending | input | 1 | Memory transaction in flight |
| procMemEn | output | 1 | Processor memory-path enable |
| procSoftReset | output | 1 | Processor-path soft reset pulse |

## Verification
The bench goes after the same-cycle write collision. A design that ignored priority would drop or corrupt one of the two writes, or acknowledge the processor too early. It probes launch validation at the exact boundary values: kind NUM_TYPES-1 against NUM_TYPES, and width MIN_WH against MIN_WH+1. An off-by-one there would either start an illegal object or refuse a legal one. It holds memPending and drawBusy high across soft reset and enable-clear requests, so a design that acted at once would cut a live transfer. It also sends object writes during busy, which a leaky design would let change the engine's inputs. Finally, it counts busy cycles to exactly TIMEOUT and TIMEOUT+1 to catch a watchdog that fires one cycle early or late.

// File: rtl/cmd_dec_pkg.sv
package cmd_dec_pkg;
  localparam int DATA_W   = 32;
  localparam int NUM_REGS = 8;

  // shared register indices (address equals index)
  localparam int REG_HTIM  = 0;
  localparam int REG_VTIM  = 1;
  localparam int REG_TYPE  = 2;
  localparam int REG_WID   = 3;
  localparam int REG_HGT   = 4;
  localparam int REG_PIX   = 5;
  localparam int REG_MASK  = 6;
  localparam int REG_FILL  = 7;
  localparam int NUM_TIMING = 2;

  // command addresses
  localparam int ADR_LAUNCH = 8;
  localparam int ADR_PUSH   = 9;
  localparam int ADR_SRST   = 16;
  localparam int ADR_EN_SET = 18;
  localparam int ADR_EN_CLR = 19;

  typedef struct packed {
    logic [NUM_REGS-1:0] load;
    logic [DATA_W-1:0]   data;
  } regStrobe_t;
endpackage

// File: rtl/cmd_dec_regs.sv
module cmd_dec_regs
  import cmd_dec_pkg::*;
#(
  parameter int TYPE_W    = 3,
  parameter int DIM_W     = 10,
  parameter int PIX_W     = 19,
  parameter int MASK_W    = 16,
  parameter int VALUE_W   = 8,
  parameter int NUM_TYPES = 5,
  parameter int MIN_WH    = 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  regStrobe_t         strobe,
  output logic [DATA_W-1:0]  hTiming,
  output logic [DATA_W-1:0]  vTiming,
  output logic [TYPE_W-1:0]  objType,
  output logic [DIM_W-1:0]   objWidth,
  output logic [DIM_W-1:0]   objHeight,
  output logic [PIX_W-1:0]   objStartPix,
  output logic [MASK_W-1:0]  objStartMask,
  output logic [VALUE_W-1:0] objFill,
  output logic               objValid
);
  localparam int TYPE_CMP_W = TYPE_W + 1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hTiming      <= '0;
      vTiming      <= '0;
      objType      <= '0;
      objWidth     <= '0;
      objHeight    <= '0;
      objStartPix  <= '0;
      objStartMask <= '0;
      objFill      <= '0;
    end else begin
      if (strobe.load[REG_HTIM]) hTiming      <= strobe.data;
      if (strobe.load[REG_VTIM]) vTiming      <= strobe.data;
      if (strobe.load[REG_TYPE]) objType      <= strobe.data[TYPE_W-1:0];
      if (strobe.load[REG_WID])  objWidth     <= strobe.data[DIM_W-1:0];
      if (strobe.load[REG_HGT])  objHeight    <= strobe.data[DIM_W-1:0];
      if (strobe.load[REG_PIX])  objStartPix  <= strobe.data[PIX_W-1:0];
      if (strobe.load[REG_MASK]) objStartMask <= strobe.data[MASK_W-1:0];
      if (strobe.load[REG_FILL]) objFill      <= strobe.data[VALUE_W-1:0];
    end
  end

  // launch legality as seen from the currently loaded fields
  always_comb begin
    objValid = ({1'b0, objType} < TYPE_CMP_W'(NUM_TYPES))
            && (objWidth  > DIM_W'(MIN_WH))
            && (objHeight > DIM_W'(MIN_WH));
  end
endmodule

// File: rtl/cmd_dec_ctrl.sv
module cmd_dec_ctrl
  import cmd_dec_pkg::*;
#(
  parameter int ADDR_W  = 5,
  parameter int TIMEOUT = 4096
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              serWe,
  input  logic [ADDR_W-1:0] serAddr,
  input  logic [DATA_W-1:0] serWdata,
  input  logic              procWe,
  input  logic [ADDR_W-1:0] procAddr,
  input  logic [DATA_W-1:0] procWdata,
  input  logic              procRe,
  input  logic              drawBusy,
  input  logic              memPending,
  input  logic              objValid,
  output regStrobe_t        strobe,
  output logic              procWrAck,
  output logic              procRdy,
  output logic [DATA_W-1:0] procRdata,
  output logic              drawStart,
  output logic              fifoPush,
  output logic              procMemEn,
  output logic              procSoftReset,
  output logic              drawTimeout
);
  localparam int CNT_W = $clog2(TIMEOUT + 1);

  logic              procAccept;
  logic              wrValid;
  logic [ADDR_W-1:0] wrAddr;
  logic [DATA_W-1:0] wrData;
  logic              engaged;
  logic [NUM_REGS-1:0] loadVec;
  logic              launchHit;
  logic              srstHit;
  logic              enSetHit;
  logic              enClrHit;
  logic              clrPending;
  logic              srPending;
  logic              srIssue;
  logic [CNT_W-1:0]  busyCnt;

  // serial side wins; processor waits while its ack is out
  always_comb begin
    procAccept = procWe && !serWe && !procWrAck;
    wrValid    = serWe || procAccept;
    wrAddr     = serWe ? serAddr  : procAddr;
    wrData     = serWe ? serWdata : procWdata;
    engaged    = drawStart || drawBusy;
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_load
    localparam bit IS_TIMING = (g < NUM_TIMING);
    assign loadVec[g] = wrValid && (wrAddr == ADDR_W'(g)) && (IS_TIMING || !engaged);
  end

  always_comb begin
    strobe.load = loadVec;
    strobe.data = wrData;
  end

  always_comb begin
    launchHit = wrValid && (wrAddr == ADDR_W'(ADR_LAUNCH));
    srstHit   = wrValid && (wrAddr == ADDR_W'(ADR_SRST));
    enClrHit  = wrValid && (wrAddr == ADDR_W'(ADR_EN_CLR));
    enSetHit  = serWe && (serAddr == ADDR_W'(ADR_EN_SET));
    fifoPush  = serWe && (serAddr == ADDR_W'(ADR_PUSH));
    srIssue   = srPending && !memPending && !drawBusy && !drawStart;
  end

  // host handshakes and launch
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      procWrAck <= 1'b0;
      procRdy   <= 1'b0;
      procRdata <= '0;
      drawStart <= 1'b0;
    end else begin
      procWrAck <= procAccept;
      procRdy   <= procRe && !procRdy;
      if (procRe && !procRdy) procRdata <= DATA_W'({drawTimeout, drawBusy});
      drawStart <= launchHit && objValid && !engaged;
    end
  end

  // memory-path enable with deferred clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      procMemEn  <= 1'b0;
      clrPending <= 1'b0;
    end else if (enSetHit) begin
      procMemEn  <= 1'b1;
      clrPending <= 1'b0;
    end else if (enClrHit) begin
      clrPending <= 1'b1;
    end else if (clrPending && !memPending) begin
      procMemEn  <= 1'b0;
      clrPending <= 1'b0;
    end
  end

  // deferred soft reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srPending     <= 1'b0;
      procSoftReset <= 1'b0;
    end else begin
      procSoftReset <= srIssue;
      if (srstHit)      srPending <= 1'b1;
      else if (srIssue) srPending <= 1'b0;
    end
  end

  // busy watchdog
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyCnt     <= '0;
      drawTimeout <= 1'b0;
    end else if (!drawBusy) begin
      busyCnt <= '0;
    end else if (busyCnt == CNT_W'(TIMEOUT)) begin
      drawTimeout <= 1'b1;
    end else begin
      busyCnt <= busyCnt + 1'b1;
    end
  end
endmodule

// File: rtl/dual_host_cmd_decoder.sv
module dual_host_cmd_decoder
  import cmd_dec_pkg::*;
#(
  parameter int ADDR_W    = 5,
  parameter int TYPE_W    = 3,
  parameter int DIM_W     = 10,
  parameter int PIX_W     = 19,
  parameter int MASK_W    = 16,
  parameter int VALUE_W   = 8,
  parameter int NUM_TYPES = 5,
  parameter int MIN_WH    = 1,
  parameter int TIMEOUT   = 4096
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               serWe,
  input  logic [ADDR_W-1:0]  serAddr,
  input  logic [DATA_W-1:0]  serWdata,
  input  logic               serRe,
  output logic [DATA_W-1:0]  serRdata,
  input  logic               procWe,
  input  logic [ADDR_W-1:0]  procAddr,
  input  logic [DATA_W-1:0]  procWdata,
  output logic               procWrAck,
  input  logic               procRe,
  output logic [DATA_W-1:0]  procRdata,
  output logic               procRdy,
  output logic               fifoPush,
  output logic [DATA_W-1:0]  fifoWdata,
  output logic               fifoPop,
  input  logic [DATA_W-1:0]  fifoRdata,
  output logic [DATA_W-1:0]  hTiming,
  output logic [DATA_W-1:0]  vTiming,
  output logic [TYPE_W-1:0]  objType,
  output logic [DIM_W-1:0]   objWidth,
  output logic [DIM_W-1:0]   objHeight,
  output logic [PIX_W-1:0]   objStartPix,
  output logic [MASK_W-1:0]  objStartMask,
  output logic [VALUE_W-1:0] objFill,
  output logic               drawStart,
  input  logic               drawBusy,
  output logic               drawTimeout,
  input  logic               memPending,
  output logic               procMemEn,
  output logic               procSoftReset
);
  regStrobe_t strobe;
  logic       objValid;

  assign serRdata  = fifoRdata;
  assign fifoPop   = serRe;
  assign fifoWdata = serWdata;

  cmd_dec_ctrl #(
    .ADDR_W (ADDR_W),
    .TIMEOUT(TIMEOUT)
  ) i_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .serWe        (serWe),
    .serAddr      (serAddr),
    .serWdata     (serWdata),
    .procWe       (procWe),
    .procAddr     (procAddr),
    .procWdata    (procWdata),
    .procRe       (procRe),
    .drawBusy     (drawBusy),
    .memPending   (memPending),
    .objValid     (objValid),
    .strobe       (strobe),
    .procWrAck    (procWrAck),
    .procRdy      (procRdy),
    .procRdata    (procRdata),
    .drawStart    (drawStart),
    .fifoPush     (fifoPush),
    .procMemEn    (procMemEn),
    .procSoftReset(procSoftReset),
    .drawTimeout  (drawTimeout)
  );

  cmd_dec_regs #(
    .TYPE_W   (TYPE_W),
    .DIM_W    (DIM_W),
    .PIX_W    (PIX_W),
    .MASK_W   (MASK_W),
    .VALUE_W  (VALUE_W),
    .NUM_TYPES(NUM_TYPES),
    .MIN_WH   (MIN_WH)
  ) i_regs (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .hTiming     (hTiming),
    .vTiming     (vTiming),
    .objType     (objType),
    .objWidth    (objWidth),
    .objHeight   (objHeight),
    .objStartPix (objStartPix),
    .objStartMask(objStartMask),
    .objFill     (objFill),
    .objValid    (objValid)
  );
endmodule

// File: rtl/cmd_dec_checker.sv
module cmd_dec_checker #(
  parameter int TYPE_W    = 3,
  parameter int DIM_W     = 10,
  parameter int PIX_W     = 19,
  parameter int MASK_W    = 16,
  parameter int VALUE_W   = 8,
  parameter int NUM_TYPES = 5,
  parameter int MIN_WH    = 1
) (
  input logic               clk,
  input logic               rstN,
  input logic               drawStart,
  input logic               drawBusy,
  input logic [TYPE_W-1:0]  objType,
  input logic [DIM_W-1:0]   objWidth,
  input logic [DIM_W-1:0]   objHeight,
  input logic [PIX_W-1:0]   objStartPix,
  input logic [MASK_W-1:0]  objStartMask,
  input logic [VALUE_W-1:0] objFill,
  input logic               memPending,
  input logic               procMemEn,
  input logic               procSoftReset,
  input logic               procWrAck,
  input logic               procRdy,
  input logic               drawTimeout
);
  assert_wrack_single_R2: assert property (@(posedge clk) disable iff (!rstN)
    procWrAck |=> !procWrAck);

  assert_start_single_R4: assert property (@(posedge clk) disable iff (!rstN)
    drawStart |=> !drawStart);

  assert_start_legal_R4: assert property (@(posedge clk) disable iff (!rstN)
    drawStart |-> (int'(objType) < NUM_TYPES) && (int'(objWidth) > MIN_WH)
                  && (int'(objHeight) > MIN_WH));

  assert_obj_frozen_R5: assert property (@(posedge clk) disable iff (!rstN)
    drawBusy |=> $stable({objType, objWidth, objHeight, objStartPix, objStartMask, objFill}));

  assert_srst_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(procSoftReset) |-> $past(!memPending && !drawBusy));

  assert_srst_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    procSoftReset |=> !procSoftReset);

  assert_en_clear_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(procMemEn) |-> $past(!memPending));

  assert_rdy_single_R10: assert property (@(posedge clk) disable iff (!rstN)
    procRdy |=> !procRdy);

  assert_timeout_sticky_R12: assert property (@(posedge clk) disable iff (!rstN)
    drawTimeout |=> drawTimeout);
endmodule

bind dual_host_cmd_decoder cmd_dec_checker #(
  .TYPE_W   (TYPE_W),
  .DIM_W    (DIM_W),
  .PIX_W    (PIX_W),
  .MASK_W   (MASK_W),
  .VALUE_W  (VALUE_W),
  .NUM_TYPES(NUM_TYPES),
  .MIN_WH   (MIN_WH)
) i_checker (
  .clk          (clk),
  .rstN         (rstN),
  .drawStart    (drawStart),
  .drawBusy     (drawBusy),
  .objType      (objType),
  .objWidth     (objWidth),
  .objHeight    (objHeight),
  .objStartPix  (objStartPix),
  .objStartMask (objStartMask),
  .objFill      (objFill),
  .memPending   (memPending),
  .procMemEn    (procMemEn),
  .procSoftReset(procSoftReset),
  .procWrAck    (procWrAck),
  .procRdy      (procRdy),
  .drawTimeout  (drawTimeout)
);

// File: tb/test_dual_host_cmd_decoder.sv
`timescale 1ns/1ps
module test_dual_host_cmd_decoder;
  localparam int ADDR_W = 5;
  localparam int DW = 32;
  localparam int TYPE_W = 3, DIM_W = 10, PIX_W = 19, MASK_W = 16, VALUE_W = 8;
  localparam int NUM_TYPES = 5, MIN_WH = 1, TIMEOUT = 20;

  logic clk = 0, rstN = 0;
  logic serWe = 0, serRe = 0, procWe = 0, procRe = 0;
  logic [ADDR_W-1:0] serAddr = '0, procAddr = '0;
  logic [DW-1:0] serWdata = '0, procWdata = '0, fifoRdata = '0;
  logic drawBusy = 0, memPending = 0;
  logic [DW-1:0] serRdata, procRdata, fifoWdata, hTiming, vTiming;
  logic procWrAck, procRdy, fifoPush, fifoPop, drawStart, drawTimeout, procMemEn, procSoftReset;
  logic [TYPE_W-1:0] objType;
  logic [DIM_W-1:0] objWidth, objHeight;
  logic [PIX_W-1:0] objStartPix;
  logic [MASK_W-1:0] objStartMask;
  logic [VALUE_W-1:0] objFill;

  int nVec = 0, nFail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  dual_host_cmd_decoder #(.ADDR_W(ADDR_W), .TIMEOUT(TIMEOUT)) i_dual_host_cmd_decoder (.*);

  // {serial host, address, data}
  localparam logic [37:0] VEC [8] = '{
    {1'b1, 5'd0, 32'h0320_0290},
    {1'b0, 5'd1, 32'h020D_01E0},
    {1'b1, 5'd2, 32'h0000_0002},
    {1'b0, 5'd3, 32'h0000_0014},
    {1'b1, 5'd4, 32'h0000_000A},
    {1'b0, 5'd5, 32'h000F_FFFF},
    {1'b1, 5'd6, 32'h1234_00AB},
    {1'b0, 5'd7, 32'h0000_015A}
  };

  function automatic logic [DW-1:0] fieldMask(input int a);
    case (a)
      0, 1: return '1;
      2: return (32'd1 << TYPE_W) - 1;
      3, 4: return (32'd1 << DIM_W) - 1;
      5: return (32'd1 << PIX_W) - 1;
      6: return (32'd1 << MASK_W) - 1;
      default: return (32'd1 << VALUE_W) - 1;
    endcase
  endfunction

  function automatic logic [DW-1:0] readOut(input int a);
    case (a)
      0: return hTiming;
      1: return vTiming;
      2: return DW'(objType);
      3: return DW'(objWidth);
      4: return DW'(objHeight);
      5: return DW'(objStartPix);
      6: return DW'(objStartMask);
      default: return DW'(objFill);
    endcase
  endfunction

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    nVec++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic serWrite(input int a, input logic [DW-1:0] d);
    @(negedge clk);
    serWe = 1; serAddr = ADDR_W'(a); serWdata = d;
    @(negedge clk);
    serWe = 0;
  endtask

  task automatic procWrite(input int a, input logic [DW-1:0] d);
    @(negedge clk);
    procWe = 1; procAddr = ADDR_W'(a); procWdata = d;
    do @(negedge clk); while (!procWrAck);
    procWe = 0;
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog: run hung actual=1 expected=0");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nFail);
      $finish;
    end
  end

  initial begin
    int pulses;
    tick(3);
    rstN = 1;
    tick(1);
    // R1 reset state
    chk("R1 reset hTiming", hTiming, 0);
    chk("R1 reset objType", DW'(objType), 0);
    chk("R1 reset ctl", DW'({drawStart, procMemEn, procSoftReset, procWrAck, drawTimeout}), 0);

    // R1 table walk from both hosts
    foreach (VEC[i]) begin
      if (VEC[i][37]) serWrite(int'(VEC[i][36:32]), VEC[i][31:0]);
      else            procWrite(int'(VEC[i][36:32]), VEC[i][31:0]);
      chk($sformatf("R1 vec %0d", i), readOut(int'(VEC[i][36:32])),
          VEC[i][31:0] & fieldMask(int'(VEC[i][36:32])));
    end

    // R2 plain processor write: ack one cycle after acceptance, one cycle wide
    @(negedge clk);
    procWe = 1; procAddr = 5'd0; procWdata = 32'h1111_2222;
    @(negedge clk);
    chk("R2 ack after accept", DW'(procWrAck), 1);
    chk("R2 data", hTiming, 32'h1111_2222);
    procWe = 0;
    @(negedge clk);
    chk("R2 ack single", DW'(procWrAck), 0);

    // R3 collision
    @(negedge clk);
    serWe = 1; serAddr = 5'd0; serWdata = 32'hAAAA_0000;
    procWe = 1; procAddr = 5'd1; procWdata = 32'hBBBB_0000;
    @(negedge clk);
    serWe = 0;
    chk("R3 serial applied", hTiming, 32'hAAAA_0000);
    chk("R3 proc held", vTiming, 32'h020D_01E0);
    chk("R3 no early ack", DW'(procWrAck), 0);
    @(negedge clk);
    chk("R3 proc late ack", DW'(procWrAck), 1);
    chk("R3 proc applied", vTiming, 32'hBBBB_0000);
    procWe = 0;
    tick(1);

    // R4 valid launch (type 2, w 20, h 10)
    serWrite(8, 0);
    chk("R4 start pulse", DW'(drawStart), 1);
    drawBusy = 1;
    @(negedge clk);
    chk("R4 start single", DW'(drawStart), 0);
    // R5 writes ignored while busy, timing still writable
    serWrite(2, 3);
    chk("R5 type frozen", DW'(objType), 2);
    procWrite(3, 99);
    chk("R5 width frozen", DW'(objWidth), 20);
    serWrite(8, 0);
    chk("R5 no launch busy", DW'(drawStart), 0);
    serWrite(0, 32'h0000_5555);
    chk("R5 timing writable", hTiming, 32'h0000_5555);
    drawBusy = 0;
    tick(1);

    // R4 boundaries
    serWrite(2, NUM_TYPES);
    serWrite(8, 0);
    chk("R4 kind==NUM_TYPES rejected", DW'(drawStart), 0);
    serWrite(2, NUM_TYPES - 1);
    serWrite(3, MIN_WH);
    serWrite(8, 0);
    chk("R4 width==MIN rejected", DW'(drawStart), 0);
    serWrite(3, MIN_WH + 1);
    serWrite(4, MIN_WH);
    procWrite(8, 0);
    chk("R4 height==MIN rejected", DW'(drawStart), 0);
    serWrite(4, MIN_WH + 1);
    serWrite(8, 0);
    chk("R4 edge values accepted", DW'(drawStart), 1);
    tick(1);

    // R7 processor cannot enable or push
    @(negedge clk);
    procWe = 1; procAddr = 5'd9; procWdata = 32'h77;
    #1 chk("R7 proc no push", DW'(fifoPush), 0);
    do @(negedge clk); while (!procWrAck);
    procWe = 0;
    procWrite(18, 1);
    chk("R7 proc enable ignored", DW'(procMemEn), 0);
    // R6
    serWrite(18, 1);
    chk("R6 serial enable", DW'(procMemEn), 1);

    // R9 deferred enable clear
    memPending = 1;
    procWrite(19, 0);
    tick(3);
    chk("R9 held while pending", DW'(procMemEn), 1);
    memPending = 0;
    @(negedge clk);
    chk("R9 cleared when idle", DW'(procMemEn), 0);

    // R8 deferred soft reset
    memPending = 1;
    serWrite(16, 0);
    tick(3);
    chk("R8 no reset mem pending", DW'(procSoftReset), 0);
    memPending = 0; drawBusy = 1;
    tick(3);
    chk("R8 no reset busy", DW'(procSoftReset), 0);
    drawBusy = 0;
    @(negedge clk);
    chk("R8 reset issued", DW'(procSoftReset), 1);
    pulses = 0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      if (procSoftReset) pulses++;
    end
    chk("R8 single pulse", DW'(pulses), 0);

    // R10 MMIO read
    drawBusy = 1;
    @(negedge clk);
    procRe = 1;
    @(negedge clk);
    chk("R10 ready", DW'(procRdy), 1);
    chk("R10 busy bit", procRdata, 32'h1);
    procRe = 0;
    @(negedge clk);
    chk("R10 ready single", DW'(procRdy), 0);
    drawBusy = 0;
    tick(1);

    // R11 serial read and push
    fifoRdata = 32'hCAFE_F00D; serRe = 1;
    #1 chk("R11 read data", serRdata, 32'hCAFE_F00D);
    chk("R11 pop", DW'(fifoPop), 1);
    @(negedge clk);
    serRe = 0;
    #1 chk("R11 pop idle", DW'(fifoPop), 0);
    serWe = 1; serAddr = 5'd9; serWdata = 32'h0BAD_BEEF;
    #1 chk("R11 push", DW'({fifoPush}), 1);
    chk("R11 push data", fifoWdata, 32'h0BAD_BEEF);
    @(negedge clk);
    serWe = 0;

    // R12 watchdog boundary
    drawBusy = 1;
    tick(TIMEOUT);
    chk("R12 not yet", DW'(drawTimeout), 0);
    tick(1);
    chk("R12 timeout", DW'(drawTimeout), 1);
    drawBusy = 0;
    tick(3);
    chk("R12 sticky", DW'(drawTimeout), 1);
    @(negedge clk);
    procRe = 1;
    @(negedge clk);
    procRe = 0;
    chk("R12 status bit", procRdata, 32'h2);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nFail);
    $finish;
  end
endmodule